// File: doc/BRIEF.md
# Shared Packet Buffer Manager for a Multi-Endpoint Serial Bus Controller

This block manages one packet buffer RAM shared by every endpoint of a serial bus controller. There is a control endpoint (endpoint 0) and 15 further endpoints in each direction. The control endpoint owns a fixed 64-byte area at the bottom of the RAM. Software gives every other endpoint a region: a start address, a power-of-two size and a choice of one or two packets. The block turns byte accesses relative to an endpoint into physical RAM cycles. It tracks how many committed packets each endpoint holds and reports a full flag and an empty flag for each one.

Every access carries a bus token direction (IN or OUT) and an endpoint number. The block picks the transmit or receive endpoint from the token direction and the controller role. An access is a byte write, a byte read, a packet commit or a packet release. Accesses come from the CPU or from a DMA request port, and DMA may not touch the control endpoint. A transmit endpoint and the receive endpoint with the same number may point at the same region. Only one of them may hold data at a time, and an access that breaks this rule is refused and flagged. Badly placed regions, writes that run past a packet and such conflicts each set a sticky flag. The RAM itself sits outside the block. The block drives a registered single-port RAM request.

Top module: `fifo_mgr`

## Requirements
- R1: A configuration write programs one endpoint slot {cfg_rx_i, cfg_ep_i} with a base byte address, a size code c (region size 8<<c bytes, c from 0 to 10), a single/double mode and an enable. Writes that name endpoint 0 are ignored.
- R2: Endpoint 0 is fixed in both directions: base 0, 64 bytes, one packet, always enabled. Its RAM addresses stay below 64.
- R3: A region with code above 10, a base below 64, or base plus size beyond RAM_BYTES sets the sticky cfg_err_o. Every access to that slot is then ignored until a valid configuration is written to it.
- R4: Slot selection is dir_rx = acc_in_i XNOR mode_host_i. With mode_host_i=0, IN uses the transmit slot and OUT uses the receive slot; with mode_host_i=1 the mapping is swapped.
- R5: acc_op_i is 0 for a byte write, 1 for a byte read, 2 for a commit and 3 for a release. An accepted read or write shows ram_en_o (and ram_we_o for a write) one cycle later. The address is base + half*packet_size + offset. Each direction's offset advances by one per accepted byte.
- R6: In single mode the packet size is the region size. A commit makes the slot full and a release makes it empty again. A commit to a full slot, or a release from an empty one, is ignored.
- R7: In double mode each half is one packet. The write half toggles on each commit and the read half on each release. The slot is full with two committed packets and not empty with one. Offsets return to 0 on commit (write side) and on release (read side).
- R8: A write to a full slot, or at an offset equal to the packet size, performs no RAM cycle and sets the sticky ovf_o.
- R9: A read from an empty slot, or at a read offset equal to the packet size, performs no RAM cycle.
- R10: An access is refused and sets the sticky conflict_o when the slot's opposite-direction partner is enabled, has the same base, and is active (it holds a committed packet or has a nonzero offset).
- R11: DMA accesses to endpoint 0, and accesses to disabled slots, perform no RAM cycle.
- R12: A configuration write clears that slot's occupancy, halves and offsets.
- R13: After reset: ram_en_o=0, full_o all 0, empty_o all 1 (bit index = dir_rx*NEP + endpoint), and all sticky flags 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_host_i | input | 1 | Role: 1 host, 0 peripheral |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_rx_i | input | 1 | Configuration targets the receive slot |
| cfg_ep_i | input | log2(NEP) | Configured endpoint number |
| cfg_base_i | input | log2(RAM_BYTES) | Region base byte address |
| cfg_szc_i | input | 4 | Size code, region = 8<<code bytes |
| cfg_dbl_i | input | 1 | Two-packet mode |
| cfg_en_i | input | 1 | Slot enable |
| acc_valid_i | input | 1 | Access request |
| acc_in_i | input | 1 | Token direction: 1 IN, 0 OUT |
| acc_ep_i | input | log2(NEP) | Accessed endpoint |
| acc_op_i | input | 2 | Operation code (R5) |
| acc_dma_i | input | 1 | Request comes from DMA |
| acc_wdata_i | input | 8 | Write byte |
| ram_en_o | output | 1 | RAM cycle enable |
| ram_we_o | output | 1 | RAM write enable |
| ram_addr_o | output | log2(RAM_BYTES) | RAM byte address |
| ram_wdata_o | output | 8 | RAM write byte |
| full_o | output | 2*NEP | Per-slot full flag |
| empty_o | output | 2*NEP | Per-slot empty flag |
| cfg_err_o | output | 1 | Sticky configuration error |
| ovf_o | output | 1 | Sticky write overflow |
| conflict_o | output | 1 | Sticky shared-region conflict |

## Verification
The bench builds the block with NEP=16, MAX_BUF=8192, CTRL_BYTES=64 and RAM_BYTES=4096. The smaller RAM lets a 16-byte region placed near address 4090 run past the end of memory, and lets a code-11 region be rejected both for its size and for its span. Keeping the full endpoint count and maximum buffer size means the code range and slot indexing are the ones a full-size build uses. The role swap, both buffering modes, the end-of-packet boundary, the shared-region conflict and the recovery after reconfiguration are all driven through the ports.

// File: rtl/fifo_mgr_pkg.sv
package fifo_mgr_pkg;
  typedef enum logic [1:0] {
    OP_WR      = 2'd0,
    OP_RD      = 2'd1,
    OP_COMMIT  = 2'd2,
    OP_RELEASE = 2'd3
  } op_e;
endpackage

// File: rtl/fifo_mgr_cfg.sv
module fifo_mgr_cfg #(
  parameter int NEP        = 16,
  parameter int AW         = 15,
  parameter int CTRL_BYTES = 64,
  parameter int RAM_BYTES  = 32768,
  parameter int MAX_CODE   = 10,
  localparam int NSLOT     = 2 * NEP,
  localparam int EPW       = $clog2(NEP)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic                        rx_i,
  input  logic [EPW-1:0]              ep_i,
  input  logic [AW-1:0]               base_i,
  input  logic [3:0]                  szc_i,
  input  logic                        dbl_i,
  input  logic                        en_i,
  output logic [NSLOT-1:0][AW-1:0]    base_o,
  output logic [NSLOT-1:0][3:0]       szc_o,
  output logic [NSLOT-1:0]            dbl_o,
  output logic [NSLOT-1:0]            en_o,
  output logic [NSLOT-1:0]            bad_o,
  output logic [NSLOT-1:0]            clr_o,
  output logic                        err_o
);
  localparam int CTRL_CODE = $clog2(CTRL_BYTES / 8);

  logic [EPW:0]  wslot;
  logic          wr_ok;
  logic [31:0]   sz_new;
  logic          bad_new;

  assign wslot   = {rx_i, ep_i};
  assign wr_ok   = we_i && (ep_i != '0);
  assign sz_new  = 32'd8 << szc_i;
  assign bad_new = (32'(szc_i) > 32'(MAX_CODE)) ||
                   (32'(base_i) < 32'(CTRL_BYTES)) ||
                   (32'(base_i) + sz_new > 32'(RAM_BYTES));

  for (genvar k = 0; k < NSLOT; k++) begin : g_slot
    if ((k % NEP) == 0) begin : g_ctrl
      // control endpoint region is hard-wired
      assign base_o[k] = '0;
      assign szc_o[k]  = 4'(CTRL_CODE);
      assign dbl_o[k]  = 1'b0;
      assign en_o[k]   = 1'b1;
      assign bad_o[k]  = 1'b0;
      assign clr_o[k]  = 1'b0;
    end else begin : g_prog
      logic          hit;
      logic [AW-1:0] base_q;
      logic [3:0]    szc_q;
      logic          dbl_q, en_q, bad_q;
      assign hit = wr_ok && (wslot == (EPW+1)'(k));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          base_q <= '0;
          szc_q  <= '0;
          dbl_q  <= 1'b0;
          en_q   <= 1'b0;
          bad_q  <= 1'b0;
        end else if (hit) begin
          base_q <= base_i;
          szc_q  <= szc_i;
          dbl_q  <= dbl_i;
          en_q   <= en_i;
          bad_q  <= bad_new;
        end
      end
      assign base_o[k] = base_q;
      assign szc_o[k]  = szc_q;
      assign dbl_o[k]  = dbl_q;
      assign en_o[k]   = en_q;
      assign bad_o[k]  = bad_q;
      assign clr_o[k]  = hit;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               err_o <= 1'b0;
    else if (wr_ok && bad_new) err_o <= 1'b1;
  end
endmodule

// File: rtl/fifo_mgr_trk.sv
module fifo_mgr_trk #(
  parameter int OW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          cm_i,
  input  logic          rl_i,
  input  logic          dbl_i,
  output logic [OW-1:0] wr_off_o,
  output logic [OW-1:0] rd_off_o,
  output logic          wr_half_o,
  output logic          rd_half_o,
  output logic [1:0]    cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_off_o  <= '0;
      rd_off_o  <= '0;
      wr_half_o <= 1'b0;
      rd_half_o <= 1'b0;
      cnt_o     <= '0;
    end else if (clr_i) begin
      wr_off_o  <= '0;
      rd_off_o  <= '0;
      wr_half_o <= 1'b0;
      rd_half_o <= 1'b0;
      cnt_o     <= '0;
    end else begin
      if (wr_i) wr_off_o <= wr_off_o + 1'b1;
      if (rd_i) rd_off_o <= rd_off_o + 1'b1;
      if (cm_i) begin
        wr_off_o <= '0;
        cnt_o    <= cnt_o + 1'b1;
        if (dbl_i) wr_half_o <= ~wr_half_o;
      end
      if (rl_i) begin
        rd_off_o <= '0;
        cnt_o    <= cnt_o - 1'b1;
        if (dbl_i) rd_half_o <= ~rd_half_o;
      end
    end
  end
endmodule

// File: rtl/fifo_mgr_xlat.sv
module fifo_mgr_xlat #(
  parameter int AW = 15,
  parameter int OW = 14
) (
  input  logic [AW-1:0] base_i,
  input  logic [3:0]    szc_i,
  input  logic          dbl_i,
  input  logic          half_i,
  input  logic [OW-1:0] off_i,
  output logic [OW-1:0] pkt_o,
  output logic [1:0]    cap_o,
  output logic [AW-1:0] addr_o
);
  assign pkt_o  = OW'(dbl_i ? ((32'd8 << szc_i) >> 1) : (32'd8 << szc_i));
  assign cap_o  = dbl_i ? 2'd2 : 2'd1;
  assign addr_o = AW'(32'(base_i) + (half_i ? 32'(pkt_o) : 32'd0) + 32'(off_i));
endmodule

// File: rtl/fifo_mgr.sv
module fifo_mgr #(
  parameter int NEP        = 16,
  parameter int RAM_BYTES  = 32768,
  parameter int CTRL_BYTES = 64,
  parameter int MAX_BUF    = 8192,
  localparam int AW        = $clog2(RAM_BYTES),
  localparam int EPW       = $clog2(NEP),
  localparam int NSLOT     = 2 * NEP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_host_i,
  input  logic             cfg_we_i,
  input  logic             cfg_rx_i,
  input  logic [EPW-1:0]   cfg_ep_i,
  input  logic [AW-1:0]    cfg_base_i,
  input  logic [3:0]       cfg_szc_i,
  input  logic             cfg_dbl_i,
  input  logic             cfg_en_i,
  input  logic             acc_valid_i,
  input  logic             acc_in_i,
  input  logic [EPW-1:0]   acc_ep_i,
  input  logic [1:0]       acc_op_i,
  input  logic             acc_dma_i,
  input  logic [7:0]       acc_wdata_i,
  output logic             ram_en_o,
  output logic             ram_we_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [7:0]       ram_wdata_o,
  output logic [NSLOT-1:0] full_o,
  output logic [NSLOT-1:0] empty_o,
  output logic             cfg_err_o,
  output logic             ovf_o,
  output logic             conflict_o
);
  import fifo_mgr_pkg::*;

  localparam int OW       = $clog2(MAX_BUF) + 1;
  localparam int MAX_CODE = $clog2(MAX_BUF / 8);

  logic [NSLOT-1:0][AW-1:0] base;
  logic [NSLOT-1:0][3:0]    szc;
  logic [NSLOT-1:0]         dbl, en, bad, clr;
  logic [NSLOT-1:0][OW-1:0] wr_off, rd_off;
  logic [NSLOT-1:0]         wr_half, rd_half, active;
  logic [NSLOT-1:0][1:0]    cnt;

  op_e          op;
  logic [EPW:0] slot, partner;
  logic [OW-1:0] pkt, s_off;
  logic [1:0]   cap;
  logic [AW-1:0] addr;
  logic         usable, shared, conflict_hit, go, slot_full;
  logic         wr_ok, rd_ok, cm_ok, rl_ok, ovf_hit;

  fifo_mgr_cfg #(
    .NEP(NEP), .AW(AW), .CTRL_BYTES(CTRL_BYTES),
    .RAM_BYTES(RAM_BYTES), .MAX_CODE(MAX_CODE)
  ) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .rx_i(cfg_rx_i), .ep_i(cfg_ep_i), .base_i(cfg_base_i),
    .szc_i(cfg_szc_i), .dbl_i(cfg_dbl_i), .en_i(cfg_en_i),
    .base_o(base), .szc_o(szc), .dbl_o(dbl), .en_o(en), .bad_o(bad),
    .clr_o(clr), .err_o(cfg_err_o)
  );

  assign op      = op_e'(acc_op_i);
  assign slot    = {acc_in_i ~^ mode_host_i, acc_ep_i};
  assign partner = {~slot[EPW], acc_ep_i};
  assign s_off   = (op == OP_RD) ? rd_off[slot] : wr_off[slot];

  fifo_mgr_xlat #(.AW(AW), .OW(OW)) i_xlat (
    .base_i(base[slot]), .szc_i(szc[slot]), .dbl_i(dbl[slot]),
    .half_i((op == OP_RD) ? rd_half[slot] : wr_half[slot]),
    .off_i(s_off), .pkt_o(pkt), .cap_o(cap), .addr_o(addr)
  );

  // acceptance
  assign usable       = acc_valid_i && en[slot] && !bad[slot] &&
                        !(acc_dma_i && (acc_ep_i == '0));
  assign shared       = en[partner] && (base[partner] == base[slot]);
  assign conflict_hit = usable && shared && active[partner];
  assign go           = usable && !conflict_hit;
  assign slot_full    = (cnt[slot] == cap);
  assign ovf_hit      = go && (op == OP_WR) && (slot_full || (s_off >= pkt));
  assign wr_ok        = go && (op == OP_WR) && !slot_full && (s_off < pkt);
  assign rd_ok        = go && (op == OP_RD) && (cnt[slot] != 2'd0) && (s_off < pkt);
  assign cm_ok        = go && (op == OP_COMMIT) && !slot_full;
  assign rl_ok        = go && (op == OP_RELEASE) && (cnt[slot] != 2'd0);

  for (genvar k = 0; k < NSLOT; k++) begin : g_trk
    logic sel;
    assign sel = (slot == (EPW+1)'(k));
    fifo_mgr_trk #(.OW(OW)) i_trk (
      .clk_i, .rst_ni, .clr_i(clr[k]),
      .wr_i(wr_ok && sel), .rd_i(rd_ok && sel),
      .cm_i(cm_ok && sel), .rl_i(rl_ok && sel), .dbl_i(dbl[k]),
      .wr_off_o(wr_off[k]), .rd_off_o(rd_off[k]),
      .wr_half_o(wr_half[k]), .rd_half_o(rd_half[k]), .cnt_o(cnt[k])
    );
    assign active[k]  = (cnt[k] != 2'd0) || (wr_off[k] != '0) || (rd_off[k] != '0);
    assign full_o[k]  = (cnt[k] == (dbl[k] ? 2'd2 : 2'd1));
    assign empty_o[k] = (cnt[k] == 2'd0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ram_en_o    <= 1'b0;
      ram_we_o    <= 1'b0;
      ram_addr_o  <= '0;
      ram_wdata_o <= '0;
      ovf_o       <= 1'b0;
      conflict_o  <= 1'b0;
    end else begin
      ram_en_o <= wr_ok || rd_ok;
      ram_we_o <= wr_ok;
      if (wr_ok || rd_ok) ram_addr_o <= addr;
      if (wr_ok)          ram_wdata_o <= acc_wdata_i;
      if (ovf_hit)        ovf_o <= 1'b1;
      if (conflict_hit)   conflict_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fifo_mgr_chk.sv
module fifo_mgr_chk #(
  parameter int NEP        = 16,
  parameter int AW         = 15,
  parameter int CTRL_BYTES = 64,
  localparam int EPW       = $clog2(NEP),
  localparam int NSLOT     = 2 * NEP
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode_host_i,
  input logic             acc_valid_i,
  input logic             acc_in_i,
  input logic [EPW-1:0]   acc_ep_i,
  input logic [1:0]       acc_op_i,
  input logic             acc_dma_i,
  input logic             ram_en_o,
  input logic             ram_we_o,
  input logic [AW-1:0]    ram_addr_o,
  input logic [NSLOT-1:0] full_o,
  input logic [NSLOT-1:0] empty_o,
  input logic             cfg_err_o,
  input logic             ovf_o,
  input logic             conflict_o
);
  logic [EPW:0] slot;
  assign slot = {acc_in_i ~^ mode_host_i, acc_ep_i};

  AST_IDLE_NO_RAM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> !ram_en_o); // R5
  AST_EP0_NO_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && acc_dma_i && (acc_ep_i == '0) |=> !ram_en_o); // R11
  AST_EP0_INSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && (acc_ep_i == '0) |=> !ram_en_o || (32'(ram_addr_o) < CTRL_BYTES)); // R2
  AST_RESERVED_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && (acc_ep_i != '0) |=> !ram_en_o || (32'(ram_addr_o) >= CTRL_BYTES)); // R3
  AST_FULL_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && (acc_op_i == 2'd0) && full_o[slot] |=> !ram_we_o); // R8
  AST_EMPTY_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i && (acc_op_i == 2'd1) && empty_o[slot] |=> !ram_en_o); // R9
  AST_CFG_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |=> cfg_err_o); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o); // R8
  AST_CONFLICT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conflict_o |=> conflict_o); // R10
endmodule

bind fifo_mgr fifo_mgr_chk #(.NEP(NEP), .AW(AW), .CTRL_BYTES(CTRL_BYTES)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_host_i(mode_host_i),
  .acc_valid_i(acc_valid_i), .acc_in_i(acc_in_i), .acc_ep_i(acc_ep_i),
  .acc_op_i(acc_op_i), .acc_dma_i(acc_dma_i), .ram_en_o(ram_en_o),
  .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .full_o(full_o),
  .empty_o(empty_o), .cfg_err_o(cfg_err_o), .ovf_o(ovf_o),
  .conflict_o(conflict_o)
);

// File: tb/test_fifo_mgr.sv
module test_fifo_mgr;
  localparam int NEP = 16, RAM_BYTES = 4096, CTRL_BYTES = 64, MAX_BUF = 8192;
  localparam int AW = 12, EPW = 4, NSLOT = 32;

  logic clk = 1'b0, rst_n = 1'b0, mode_host = 1'b0;
  logic cfg_we = 0, cfg_rx = 0, cfg_dbl = 0, cfg_en = 0;
  logic [EPW-1:0] cfg_ep = '0, acc_ep = '0;
  logic [AW-1:0] cfg_base = '0;
  logic [3:0] cfg_szc = '0;
  logic acc_valid = 0, acc_in = 0, acc_dma = 0;
  logic [1:0] acc_op = '0;
  logic [7:0] acc_wdata = '0;
  logic ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0] ram_wdata;
  logic [NSLOT-1:0] full, empty;
  logic cfg_err, ovf, conflict;

  int n_chk = 0, n_fail = 0;
  bit done = 0, armed = 0;

  typedef struct { logic en; logic we; int addr; logic [7:0] data; int req; } exp_t;
  exp_t sb_q[$];

  always #10ns clk = ~clk;

  fifo_mgr #(.NEP(NEP), .RAM_BYTES(RAM_BYTES), .CTRL_BYTES(CTRL_BYTES), .MAX_BUF(MAX_BUF))
  i_fifo_mgr (
    .clk_i(clk), .rst_ni(rst_n), .mode_host_i(mode_host),
    .cfg_we_i(cfg_we), .cfg_rx_i(cfg_rx), .cfg_ep_i(cfg_ep), .cfg_base_i(cfg_base),
    .cfg_szc_i(cfg_szc), .cfg_dbl_i(cfg_dbl), .cfg_en_i(cfg_en),
    .acc_valid_i(acc_valid), .acc_in_i(acc_in), .acc_ep_i(acc_ep), .acc_op_i(acc_op),
    .acc_dma_i(acc_dma), .acc_wdata_i(acc_wdata),
    .ram_en_o(ram_en), .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .full_o(full), .empty_o(empty), .cfg_err_o(cfg_err), .ovf_o(ovf), .conflict_o(conflict)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // monitor: compare each registered RAM request against the scoreboard
  always @(posedge clk) armed <= acc_valid;
  always @(negedge clk) begin
    if (armed) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL scoreboard empty actual=%0h expected=none", ram_en);
      end else begin
        exp_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (ram_en !== it.en ||
            (it.en && (ram_we !== it.we || 32'(ram_addr) != it.addr ||
                       (it.we && ram_wdata !== it.data)))) begin
          n_fail++;
          $display("FAIL R%0d ram en/we/addr/data actual=%0b/%0b/%0d/%0h expected=%0b/%0b/%0d/%0h",
                   it.req, ram_en, ram_we, ram_addr, ram_wdata, it.en, it.we, it.addr, it.data);
        end
      end
    end
  end

  task automatic cfg(input logic rx, input int ep, input int base, input int szc,
                     input logic dbl, input logic en);
    @(negedge clk);
    cfg_we = 1; cfg_rx = rx; cfg_ep = EPW'(ep); cfg_base = AW'(base);
    cfg_szc = 4'(szc); cfg_dbl = dbl; cfg_en = en;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic acc(input logic [1:0] op, input logic tin, input int ep, input logic dma,
                     input logic [7:0] d, input logic e_en, input int e_addr, input int req);
    exp_t it;
    @(negedge clk);
    acc_valid = 1; acc_op = op; acc_in = tin; acc_ep = EPW'(ep); acc_dma = dma; acc_wdata = d;
    it.en = e_en; it.we = e_en && (op == 2'd0); it.addr = e_addr; it.data = d; it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
    acc_valid = 0; acc_dma = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13 ram_en", 32'(ram_en), 0);
    chk("R13 full", full, 0);
    chk("R13 empty", empty, 32'hFFFF_FFFF);
    chk("R13 flags", {cfg_err, ovf, conflict}, 0);

    // R1 R5 R6 single buffer, tx ep1 (peripheral IN)
    cfg(0, 1, 128, 1, 0, 1);
    acc(0, 1, 1, 0, 8'hA1, 1, 128, 1);   // R1
    acc(0, 1, 1, 0, 8'hA2, 1, 129, 5);   // R5
    acc(0, 1, 1, 0, 8'hA3, 1, 130, 5);
    chk("R6 empty before commit", 32'(empty[1]), 1);
    acc(2, 1, 1, 0, 8'h00, 0, 0, 6);
    chk("R6 full after commit", 32'(full[1]), 1);
    acc(0, 1, 1, 0, 8'hA4, 0, 0, 8);     // R8 full slot
    chk("R8 ovf set", 32'(ovf), 1);
    acc(1, 1, 1, 0, 8'h00, 1, 128, 5);
    acc(1, 1, 1, 0, 8'h00, 1, 129, 5);
    acc(3, 1, 1, 0, 8'h00, 0, 0, 6);
    chk("R6 empty after release", {30'd0, full[1], empty[1]}, 1);

    // R7 double buffer, rx ep2 (peripheral OUT), 32 bytes, halves of 16
    cfg(1, 2, 256, 2, 1, 1);
    acc(0, 0, 2, 0, 8'hB1, 1, 256, 7);
    acc(0, 0, 2, 0, 8'hB2, 1, 257, 7);
    acc(2, 0, 2, 0, 8'h00, 0, 0, 7);
    chk("R7 one packet", {30'd0, full[18], empty[18]}, 0);
    acc(0, 0, 2, 0, 8'hB3, 1, 272, 7);
    acc(2, 0, 2, 0, 8'h00, 0, 0, 7);
    chk("R7 full with two", 32'(full[18]), 1);
    acc(0, 0, 2, 0, 8'hB9, 0, 0, 8);     // R8
    acc(1, 0, 2, 0, 8'h00, 1, 256, 7);
    acc(3, 0, 2, 0, 8'h00, 0, 0, 7);
    acc(1, 0, 2, 0, 8'h00, 1, 272, 7);
    acc(0, 0, 2, 0, 8'hB4, 1, 256, 7);
    chk("R7 not full after release", 32'(full[18]), 0);

    // R9 R8 packet boundary, tx ep3, 8 bytes single
    cfg(0, 3, 512, 0, 0, 1);
    acc(1, 1, 3, 0, 8'h00, 0, 0, 9);     // R9 empty read
    for (int i = 0; i < 8; i++) acc(0, 1, 3, 0, 8'(8'hC0 + i), 1, 512 + i, 5);
    acc(0, 1, 3, 0, 8'hCF, 0, 0, 8);     // R8 offset at packet size
    acc(2, 1, 3, 0, 8'h00, 0, 0, 6);
    for (int i = 0; i < 8; i++) acc(1, 1, 3, 0, 8'h00, 1, 512 + i, 9);
    acc(1, 1, 3, 0, 8'h00, 0, 0, 9);     // R9 read offset at packet size

    // R4 host role swaps direction mapping
    mode_host = 1;
    acc(1, 1, 2, 0, 8'h00, 1, 273, 4);   // R4 IN -> rx ep2
    acc(0, 0, 1, 0, 8'hD1, 1, 128, 4);   // R4 OUT -> tx ep1
    mode_host = 0;

    // R3 configuration errors
    chk("R3 no error yet", 32'(cfg_err), 0);
    cfg(0, 4, 32, 1, 0, 1);
    chk("R3 base in reserved", 32'(cfg_err), 1);
    acc(0, 1, 4, 0, 8'hE1, 0, 0, 3);
    cfg(0, 4, 4000, 1, 0, 1);
    acc(0, 1, 4, 0, 8'hE2, 1, 4000, 3);  // R3 recovery
    cfg(0, 5, 4090, 1, 0, 1);
    acc(0, 1, 5, 0, 8'hE3, 0, 0, 3);     // R3 past end of RAM
    cfg(0, 5, 1536, 11, 0, 1);
    acc(0, 1, 5, 0, 8'hE4, 0, 0, 3);     // R3 code too large

    // R10 shared region conflict
    chk("R10 no conflict yet", 32'(conflict), 0);
    cfg(0, 6, 1024, 2, 0, 1);
    cfg(1, 6, 1024, 2, 0, 1);
    acc(0, 1, 6, 0, 8'hF1, 1, 1024, 10);
    acc(0, 0, 6, 0, 8'hF2, 0, 0, 10);
    chk("R10 conflict set", 32'(conflict), 1);

    // R11 R2 control endpoint and disabled slots
    acc(0, 1, 0, 1, 8'h11, 0, 0, 11);    // R11 DMA to ep0
    acc(0, 1, 0, 0, 8'h12, 1, 0, 2);     // R2
    cfg(0, 0, 500, 1, 1, 1);             // R1 ignored for ep0
    acc(0, 1, 0, 0, 8'h13, 1, 1, 2);     // R2 unchanged region
    acc(0, 1, 1, 1, 8'h14, 1, 129, 11);  // R11 DMA allowed on ep1
    acc(0, 1, 7, 0, 8'h15, 0, 0, 11);    // R11 disabled slot
    acc(0, 0, 0, 0, 8'h16, 0, 0, 10);    // R10 rx ep0 shares active tx ep0

    // R12 reconfiguration clears tracking
    cfg(0, 1, 128, 1, 0, 1);
    acc(0, 1, 1, 0, 8'h21, 1, 128, 12);
    cfg(0, 6, 1024, 2, 0, 1);
    acc(0, 0, 6, 0, 8'h22, 1, 1024, 12);
    chk("R12 empty after reconfig", 32'(empty[6]), 1);

    repeat (3) @(negedge clk);
    chk("R5 scoreboard drained", sb_q.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule